// File: doc/BRIEF.md
# Flash block lock manager

This block guards the program and erase paths of a small NOR-style flash array, one protection record per block. It watches decoded bus write cycles (an address and a command byte), the active-low write-protect pin and a program-suspend flag from the program engine. From these it keeps every block in one of three conditions: unlocked, locked, or locked-down. A separate query address returns, without a clock delay, whether the addressed block may currently be modified.

Changing a block's protection takes two bus writes. The first is the setup byte 60h at any address. The second is an action byte at an address inside the target block. The action byte is 01h to lock, D0h to unlock, or 2Fh to lock down. Any other second byte is a command-sequence error. It raises both error bits of the status register (the program-failure bit and the erase-failure bit), and those bits stay set until the clear-status byte 50h is written.

The command decoder is a two-state machine. IDLE moves to SETUP on a 60h write. IDLE stays in IDLE and clears status on a 50h write. IDLE ignores every other byte. SETUP returns to IDLE on its next write whatever the byte is. On that write it emits one action (lock, unlock or lock-down), or a rejection, or a sequence error.

Top module: `flash_lock_mgr`

## Requirements
- R1: After reset every block is locked, `modify_ok` is 0 for every query address, both status bits are 0 and the decoder is in IDLE.
- R2: A 60h write followed by a 01h write locks the block whose index is the upper `BLK_IDX_W` bits of the second write's address. A 60h write followed by a D0h write unlocks that block. The block's new state shows on `modify_ok` right after the rising edge that samples the second write.
- R3: A 60h write followed by a 2Fh write puts the addressed block in locked-down. The block is then locked and `modify_ok` is 0 for it.
- R4: A 60h write followed by any byte other than 01h, D0h or 2Fh sets both `sts_pgm_fail` and `sts_ers_fail` and leaves the protection of every block unchanged.
- R5: While `wp_n` is 0, a D0h action aimed at a locked-down block has no effect, and `modify_ok` for that block is 0.
- R6: While `wp_n` is 1, a locked-down block is unlocked by 60h then D0h, and relocked by 60h then 01h.
- R7: When `wp_n` falls, every locked-down block that had been unlocked becomes locked again. `modify_ok` for such a block is 0 from the moment `wp_n` is 0.
- R8: The locked-down condition is removed only by reset. After a reset, a formerly locked-down block can be unlocked while `wp_n` is 0.
- R9: While `prog_susp` is 1, a 01h, D0h or 2Fh action byte is rejected: no block changes state and no status bit is set.
- R10: Once set, the status bits stay set through any number of other writes and through changes on `prog_susp` and `wp_n`. The bits are cleared only by a 50h write while the decoder is in IDLE.
- R11: An action changes only the block it addresses. All other blocks keep their state.
- R12: A write in IDLE of any byte other than 60h or 50h changes neither block state nor status.
- R13: Lock commands are not gated by any erase-suspend condition. The block takes no erase-suspend input, so commands are honoured at any time outside a program suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One decoded bus write this cycle |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | 8 | Command byte of the write |
| wp_n | input | 1 | Write-protect pin, 0 = protect |
| prog_susp | input | 1 | Program engine is suspended |
| q_addr | input | ADDR_W | Address whose block is queried |
| modify_ok | output | 1 | Queried block may be programmed or erased |
| sts_pgm_fail | output | 1 | Status program-failure bit |
| sts_ers_fail | output | 1 | Status erase-failure bit |

## Verification
Every write result is registered once. The effect of a write sampled at a rising edge is visible on `modify_ok` and on the status bits right after that edge. The query path and the write-protect override are combinational, so a change on `q_addr` or a low `wp_n` is seen in the same cycle. The bench drives each write across one rising edge and samples at the following falling edge. After each query address change it waits a short delay before it samples. A reference model of block states, updated in the same order as the writes, supplies the expected value for every block after each step.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

    localparam logic [7:0] CMD_SETUP  = 8'h60;
    localparam logic [7:0] CMD_LOCK   = 8'h01;
    localparam logic [7:0] CMD_UNLOCK = 8'hD0;
    localparam logic [7:0] CMD_DOWN   = 8'h2F;
    localparam logic [7:0] CMD_CLRSTS = 8'h50;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SETUP = 1'b1
    } dec_state_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOCK   = 2'd1,
        ACT_UNLOCK = 2'd2,
        ACT_DOWN   = 2'd3
    } lock_act_e;

endpackage

// File: rtl/flash_lock_cmd_fsm.sv
module flash_lock_cmd_fsm
    import flash_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       prog_susp,
    output lock_act_e  act,
    output logic       seq_err,
    output logic       clr_sts,
    output dec_state_e state
);

    dec_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        act      = ACT_NONE;
        seq_err  = 1'b0;
        clr_sts  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_en) begin
                    if (wr_data == CMD_SETUP) begin
                        state_nx = ST_SETUP;
                    end else if (wr_data == CMD_CLRSTS) begin
                        clr_sts = 1'b1;
                    end
                end
            end
            ST_SETUP: begin
                if (wr_en) begin
                    state_nx = ST_IDLE;
                    case (wr_data)
                        CMD_LOCK:   act = prog_susp ? ACT_NONE : ACT_LOCK;
                        CMD_UNLOCK: act = prog_susp ? ACT_NONE : ACT_UNLOCK;
                        CMD_DOWN:   act = prog_susp ? ACT_NONE : ACT_DOWN;
                        default:    seq_err = 1'b1;
                    endcase
                end
            end
        endcase
    end

endmodule

// File: rtl/flash_lock_bank.sv
module flash_lock_bank
    import flash_lock_pkg::*;
#(
    parameter int BLK_IDX_W = 3,
    localparam int NUM_BLK  = 1 << BLK_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  lock_act_e            act,
    input  logic [BLK_IDX_W-1:0] act_idx,
    input  logic                 wp_n,
    output logic [NUM_BLK-1:0]   lock_vec,
    output logic [NUM_BLK-1:0]   down_vec
);

    logic wp_q;
    logic wp_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= 1'b1;
        end else begin
            wp_q <= wp_n;
        end
    end

    assign wp_fall = wp_q && !wp_n;

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        logic hit;
        assign hit = (act_idx == BLK_IDX_W'(b));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_vec[b] <= 1'b1;
                down_vec[b] <= 1'b0;
            end else begin
                if (hit) begin
                    case (act)
                        ACT_LOCK: lock_vec[b] <= 1'b1;
                        ACT_DOWN: begin
                            lock_vec[b] <= 1'b1;
                            down_vec[b] <= 1'b1;
                        end
                        ACT_UNLOCK: begin
                            if (!(down_vec[b] && !wp_n)) begin
                                lock_vec[b] <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
                if (wp_fall && down_vec[b]) begin
                    lock_vec[b] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/flash_lock_mgr.sv
module flash_lock_mgr
    import flash_lock_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              wp_n,
    input  logic              prog_susp,
    input  logic [ADDR_W-1:0] q_addr,
    output logic              modify_ok,
    output logic              sts_pgm_fail,
    output logic              sts_ers_fail
);

    localparam int NUM_BLK = 1 << BLK_IDX_W;

    lock_act_e             act;
    logic                  seq_err;
    logic                  clr_sts;
    dec_state_e            fsm_state;
    logic [NUM_BLK-1:0]    lock_vec;
    logic [NUM_BLK-1:0]    down_vec;
    logic [BLK_IDX_W-1:0]  wr_idx;
    logic [BLK_IDX_W-1:0]  q_idx;

    assign wr_idx = wr_addr[ADDR_W-1 -: BLK_IDX_W];
    assign q_idx  = q_addr[ADDR_W-1 -: BLK_IDX_W];

    flash_lock_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .prog_susp (prog_susp),
        .act       (act),
        .seq_err   (seq_err),
        .clr_sts   (clr_sts),
        .state     (fsm_state)
    );

    flash_lock_bank #(.BLK_IDX_W(BLK_IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .act_idx  (wr_idx),
        .wp_n     (wp_n),
        .lock_vec (lock_vec),
        .down_vec (down_vec)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_pgm_fail <= 1'b0;
            sts_ers_fail <= 1'b0;
        end else if (seq_err) begin
            sts_pgm_fail <= 1'b1;
            sts_ers_fail <= 1'b1;
        end else if (clr_sts) begin
            sts_pgm_fail <= 1'b0;
            sts_ers_fail <= 1'b0;
        end
    end

    always_comb begin
        modify_ok = !lock_vec[q_idx] && !(down_vec[q_idx] && !wp_n);
    end

endmodule

// File: rtl/flash_lock_mgr_chk.sv
module flash_lock_mgr_chk
    import flash_lock_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_IDX_W = 3,
    localparam int NUM_BLK  = 1 << BLK_IDX_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [7:0]         wr_data,
    input logic               wp_n,
    input logic               prog_susp,
    input logic [ADDR_W-1:0]  q_addr,
    input logic               modify_ok,
    input logic               sts_pgm_fail,
    input logic               sts_ers_fail,
    input dec_state_e         fsm_state,
    input logic [NUM_BLK-1:0] lock_vec,
    input logic [NUM_BLK-1:0] down_vec
);

    logic [BLK_IDX_W-1:0] q_idx;
    assign q_idx = q_addr[ADDR_W-1 -: BLK_IDX_W];

    assert_ok_needs_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        modify_ok |-> !lock_vec[q_idx]);

    assert_err_from_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_pgm_fail) |-> $past(fsm_state == ST_SETUP && wr_en));

    assert_wp_low_relocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && !$past(wp_n)) |-> ((down_vec & ~lock_vec) == '0));

    assert_psusp_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_susp && wr_en && wp_n) |=> $stable(lock_vec));

    assert_sts_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_ers_fail && !(wr_en && fsm_state == ST_IDLE && wr_data == CMD_CLRSTS))
        |=> sts_ers_fail);

    assert_down_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (down_vec & ~$past(down_vec)) == '0 || $past(wr_en));

endmodule

bind flash_lock_mgr flash_lock_mgr_chk #(
    .ADDR_W    (ADDR_W),
    .BLK_IDX_W (BLK_IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .wp_n         (wp_n),
    .prog_susp    (prog_susp),
    .q_addr       (q_addr),
    .modify_ok    (modify_ok),
    .sts_pgm_fail (sts_pgm_fail),
    .sts_ers_fail (sts_ers_fail),
    .fsm_state    (fsm_state),
    .lock_vec     (lock_vec),
    .down_vec     (down_vec)
);

// File: tb/flash_lock_mgr_tb.sv
module flash_lock_mgr_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int IW = 2;
    localparam int NB = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          wp_n = 1'b1;
    logic          prog_susp = 1'b0;
    logic [AW-1:0] q_addr = '0;
    logic          modify_ok;
    logic          sts_pgm_fail;
    logic          sts_ers_fail;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit m_lock [NB];
    bit m_down [NB];
    bit m_err;
    bit m_setup;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_lock_mgr #(.ADDR_W(AW), .BLK_IDX_W(IW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wp_n         (wp_n),
        .prog_susp    (prog_susp),
        .q_addr       (q_addr),
        .modify_ok    (modify_ok),
        .sts_pgm_fail (sts_pgm_fail),
        .sts_ers_fail (sts_ers_fail)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_lock[b] = 1'b1;
            m_down[b] = 1'b0;
        end
        m_err = 1'b0;
        m_setup = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic wr(input int blk, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = AW'((blk << (AW - IW)) | (d & 3));
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (m_setup) begin
            m_setup = 1'b0;
            if (d == 8'h01 || d == 8'hD0 || d == 8'h2F) begin
                if (!prog_susp) begin
                    if (d == 8'h01) m_lock[blk] = 1'b1;
                    else if (d == 8'h2F) begin
                        m_lock[blk] = 1'b1;
                        m_down[blk] = 1'b1;
                    end else if (!(m_down[blk] && !wp_n)) m_lock[blk] = 1'b0;
                end
            end else begin
                m_err = 1'b1;
            end
        end else if (d == 8'h60) begin
            m_setup = 1'b1;
        end else if (d == 8'h50) begin
            m_err = 1'b0;
        end
    endtask

    task automatic cmd(input int blk, input logic [7:0] d);
        wr(0, 8'h60);
        wr(blk, d);
    endtask

    task automatic set_wp(input bit v);
        @(negedge clk);
        wp_n = v;
        if (!v) begin
            for (int b = 0; b < NB; b++) if (m_down[b]) m_lock[b] = 1'b1;
        end
        #1;
    endtask

    task automatic check_all(input string req);
        for (int b = 0; b < NB; b++) begin
            bit e;
            q_addr = AW'((b << (AW - IW)) | 3);
            #1;
            e = !m_lock[b] && !(m_down[b] && !wp_n);
            chk(modify_ok == e, req, modify_ok, e);
        end
        chk(sts_pgm_fail == m_err, req, sts_pgm_fail, m_err);
        chk(sts_ers_fail == m_err, req, sts_ers_fail, m_err);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        model_reset();
        do_reset();
        // R1 reset state
        check_all("R1");

        // R2 / R11 unlock blocks one at a time
        for (int b = 0; b < NB; b++) begin
            cmd(b, 8'hD0);
            check_all("R2_R11");
        end
        cmd(0, 8'h01);
        check_all("R2");

        // R3 / R6 lock-down with wp high
        cmd(1, 8'h2F);
        check_all("R3");
        cmd(1, 8'hD0);
        check_all("R6");
        cmd(1, 8'h01);
        check_all("R6");
        cmd(1, 8'hD0);
        check_all("R6");

        // R7 wp falls: unlocked down block relocks
        set_wp(1'b0);
        check_all("R7");
        repeat (2) @(negedge clk);
        check_all("R7");

        // R5 unlock blocked while wp low
        cmd(1, 8'hD0);
        check_all("R5");

        // R8 only reset clears lock-down
        do_reset();
        cmd(1, 8'hD0);
        check_all("R8");
        set_wp(1'b1);

        // R9 program suspend rejects actions
        prog_susp = 1'b1;
        cmd(2, 8'hD0);
        check_all("R9");
        cmd(1, 8'h2F);
        check_all("R9");
        prog_susp = 1'b0;

        // R13 commands honoured at any time outside program suspend
        cmd(3, 8'hD0);
        check_all("R13");

        // R4 / R10 sequence error, sticky, cleared by 50h
        cmd(2, 8'h70);
        check_all("R4");
        wr(0, 8'h01);
        prog_susp = 1'b1;
        set_wp(1'b0);
        set_wp(1'b1);
        prog_susp = 1'b0;
        check_all("R10");
        wr(0, 8'h50);
        check_all("R10");

        // R12 sweep of single bytes in IDLE
        for (int v = 0; v < 256; v++) begin
            if (v != 8'h60 && v != 8'h50) begin
                wr(v % NB, 8'(v));
                check_all("R12");
            end
        end

        // R4 / R2 / R3 sweep of every second byte
        for (int v = 0; v < 256; v++) begin
            cmd(v % NB, 8'(v));
            check_all("R4_sweep");
            if (m_err) begin
                wr(0, 8'h50);
                check_all("R10_sweep");
            end
        end

        finish_run();
    end

endmodule